// File: doc/BRIEF.md
# Radio Frame Interrupt Event Sequencer

This block follows a received packet-radio frame one octet at a time and raises status interrupts at three points: when a non-zero length header arrives, when an externally filtered MAC header has been fully received and matched, and when the frame ends. A transmit-done flag also marks frame end. Each event sets a sticky bit in a small status register. A mask selects which bits drive a single combined interrupt line, and a read strobe clears the register.

After the start-of-frame delimiter, the first octet is the length header. Its low seven bits hold the number of octets that follow: MAC header, payload and a two-octet check sequence. A separate input gives the MAC header length and is captured when the length header is accepted. The address-match verdict comes from a frame filter outside this block. It is sampled on the last header octet. An abort input, for example loss of synthesizer lock, drops a frame in progress without an end event.

Top module: `frame_irq_seq`

## Requirements
- R1: After reset, `irq_stat` is 0, `irq` is low, and the receive tracker waits for a delimiter.
- R2: The first valid octet after `sfd_det` is the length header L (`octet_data[6:0]`). If L is non-zero, status bit 0 (start) is set on the clock edge that takes that octet.
- R3: A length header of 0 sets no bit and abandons the frame. Octets that follow it have no effect until the next `sfd_det`.
- R4: Status bit 1 (address match) is set on the edge that takes body octet number m, where m is `hdr_len` captured with the length header. This happens only if `addr_match` is high in that cycle, m ≥ 1 and m+2 < L.
- R5: No address-match bit is set if `addr_match` is low on octet m, if m = 0, or if m+2 ≥ L. The value of `addr_match` on any other octet has no effect.
- R6: Status bit 2 (end) is set on the edge that takes body octet number L. The tracker then returns to waiting for a delimiter.
- R7: A high `tx_done` sets status bit 2 on the next edge, whatever the receive state.
- R8: `abort` returns the tracker to idle on the next edge. No receive event is raised in the abort cycle or for any later octet of that frame.
- R9: `sfd_det` is ignored while a frame is being received (after the delimiter and before end, abort or a zero header).
- R10: `irq` equals the OR of `irq_stat & irq_mask` at all times.
- R11: Status bits stay set until a cycle with `stat_rd` high. That cycle clears all bits. An event raised in the same cycle as the read is kept.
- R12: Changes to `hdr_len` after the length header has been accepted do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| octet_vld | input | 1 | Octet strobe, one cycle per octet |
| octet_data | input | 8 | Octet value |
| sfd_det | input | 1 | Start-of-frame delimiter detected |
| addr_match | input | 1 | Frame filter verdict |
| hdr_len | input | 7 | MAC header length in octets |
| abort | input | 1 | Abandon the current frame |
| tx_done | input | 1 | Last transmitted octet sent |
| stat_rd | input | 1 | Status read strobe, clears the register |
| irq_mask | input | 3 | Enable per status bit |
| irq_stat | output | 3 | Status: bit0 start, bit1 address match, bit2 end |
| irq | output | 1 | Combined masked interrupt |

## Verification
The risky overlap is a status read in the same cycle as a new event: a receive end on the last octet, or a `tx_done` pulse. The bench drives `stat_rd` together with that octet or pulse. It expects the older bits to be gone and the new bit to be present after the edge. A second overlap is a delimiter that arrives mid-frame together with a body octet. The bench checks that counting and the later events are not disturbed by it.

// File: rtl/frame_irq_pkg.sv
// Shared constants and types for the frame interrupt sequencer.
// Assumes three status events; bit order is fixed and visible to software.
package frame_irq_pkg;
    localparam int IRQ_N = 3;
    localparam int B_START = 0;
    localparam int B_MATCH = 1;
    localparam int B_END   = 2;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_HDR  = 2'd1,
        RX_BODY = 2'd2
    } rx_state_t;
endpackage

// File: rtl/frame_rx_tracker.sv
// Follows one received frame octet by octet and emits single-cycle event
// pulses for start, address match and end.
// Assumes: at most one octet per cycle; the length field sits in the low
// LEN_W bits of the header octet; abort overrides everything.
module frame_rx_tracker
    import frame_irq_pkg::*;
#(
    parameter int OCT_W = 8,
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             octet_vld,
    input  logic [OCT_W-1:0] octet_data,
    input  logic             sfd_det,
    input  logic             addr_match,
    input  logic [LEN_W-1:0] hdr_len,
    input  logic             abort,
    output logic             ev_start,
    output logic             ev_match,
    output logic             ev_end,
    output logic             rx_busy
);
    localparam int WW = LEN_W + 1;

    rx_state_t        state;
    logic [LEN_W-1:0] frm_len;
    logic [LEN_W-1:0] mhr_cap;
    logic             mhr_ok;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] cnt_nxt;
    logic [LEN_W-1:0] phr;
    logic             take_body;
    logic             mhr_fits;

    // Decode the header octet and the next body position.
    always_comb begin
        phr       = octet_data[LEN_W-1:0];
        cnt_nxt   = cnt + 1'b1;
        take_body = (state == RX_BODY) && octet_vld;
        mhr_fits  = (hdr_len != '0) &&
                    ((WW'(hdr_len) + WW'(2)) < WW'(phr));
    end

    // Event pulses; abort suppresses all of them.
    always_comb begin
        ev_start = !abort && (state == RX_HDR) && octet_vld && (phr != '0);
        ev_match = !abort && take_body && mhr_ok &&
                   (cnt_nxt == mhr_cap) && addr_match;
        ev_end   = !abort && take_body && (cnt_nxt == frm_len);
        rx_busy  = (state == RX_BODY);
    end

    // Frame state, captured lengths and body octet counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            frm_len <= '0;
            mhr_cap <= '0;
            mhr_ok  <= 1'b0;
            cnt     <= '0;
        end else if (abort) begin
            state <= RX_IDLE;
        end else begin
            unique case (state)
                RX_IDLE: if (sfd_det) state <= RX_HDR;
                RX_HDR: if (octet_vld) begin
                    if (phr == '0) begin
                        state <= RX_IDLE;
                    end else begin
                        state   <= RX_BODY;
                        frm_len <= phr;
                        mhr_cap <= hdr_len;
                        mhr_ok  <= mhr_fits;
                        cnt     <= '0;
                    end
                end
                RX_BODY: if (octet_vld) begin
                    cnt <= cnt_nxt;
                    if (cnt_nxt == frm_len) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/irq_status_reg.sv
// Sticky interrupt status with clear-on-read and a masked combined line.
// Assumes a set arriving in the read cycle must survive the clear.
module irq_status_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         rd,
    input  logic [N-1:0] mask,
    output logic [N-1:0] stat,
    output logic         irq
);
    // Hold bits, clear on read, let new events win over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (rd ? '0 : stat) | set;
    end

    // Combine enabled bits into one line.
    always_comb irq = |(stat & mask);
endmodule

// File: rtl/frame_irq_seq.sv
// Top of the frame interrupt sequencer: joins the receive tracker and the
// transmit-done flag into the status register.
// Assumes tx_done is a one-cycle pulse from the transmit path.
module frame_irq_seq
    import frame_irq_pkg::*;
#(
    parameter int OCT_W = 8,
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             octet_vld,
    input  logic [OCT_W-1:0] octet_data,
    input  logic             sfd_det,
    input  logic             addr_match,
    input  logic [LEN_W-1:0] hdr_len,
    input  logic             abort,
    input  logic             tx_done,
    input  logic             stat_rd,
    input  logic [IRQ_N-1:0] irq_mask,
    output logic [IRQ_N-1:0] irq_stat,
    output logic             irq
);
    logic             ev_start;
    logic             ev_match;
    logic             ev_end;
    logic             rx_busy;
    logic [IRQ_N-1:0] ev_set;

    frame_rx_tracker #(.OCT_W(OCT_W), .LEN_W(LEN_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .octet_vld  (octet_vld),
        .octet_data (octet_data),
        .sfd_det    (sfd_det),
        .addr_match (addr_match),
        .hdr_len    (hdr_len),
        .abort      (abort),
        .ev_start   (ev_start),
        .ev_match   (ev_match),
        .ev_end     (ev_end),
        .rx_busy    (rx_busy)
    );

    // Map events to their status bit positions.
    always_comb begin
        ev_set          = '0;
        ev_set[B_START] = ev_start;
        ev_set[B_MATCH] = ev_match;
        ev_set[B_END]   = ev_end | tx_done;
    end

    irq_status_reg #(.N(IRQ_N)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ev_set),
        .rd    (stat_rd),
        .mask  (irq_mask),
        .stat  (irq_stat),
        .irq   (irq)
    );
endmodule

// File: rtl/frame_irq_seq_chk.sv
// Temporal checks on the sequencer, attached by bind.
module frame_irq_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_done,
    input logic       abort,
    input logic       stat_rd,
    input logic [2:0] irq_mask,
    input logic [2:0] irq_stat,
    input logic [2:0] ev_set,
    input logic       irq,
    input logic       rx_busy,
    input logic       ev_start,
    input logic       ev_end
);
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> rx_busy);
    p_end_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_end |=> !rx_busy);
    p_tx_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> irq_stat[2]);
    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !rx_busy);
    p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_stat & irq_mask) == 3'b000) |-> !irq);
    p_read_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && ev_set == 3'b000) |=> irq_stat == 3'b000);
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((irq_stat & $past(irq_stat)) == $past(irq_stat)));
endmodule

bind frame_irq_seq frame_irq_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_done  (tx_done),
    .abort    (abort),
    .stat_rd  (stat_rd),
    .irq_mask (irq_mask),
    .irq_stat (irq_stat),
    .ev_set   (ev_set),
    .irq      (irq),
    .rx_busy  (rx_busy),
    .ev_start (ev_start),
    .ev_end   (ev_end)
);

// File: tb/frame_irq_seq_test.sv
// Bench: directed corner frames plus seeded random frames, scored against a
// requirement-level model of the status bits.
module frame_irq_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       octet_vld = 1'b0;
    logic [7:0] octet_data = '0;
    logic       sfd_det = 1'b0;
    logic       addr_match = 1'b0;
    logic [6:0] hdr_len = '0;
    logic       abort = 1'b0;
    logic       tx_done = 1'b0;
    logic       stat_rd = 1'b0;
    logic [2:0] irq_mask = 3'b111;
    logic [2:0] irq_stat;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic [2:0] exp_stat = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    frame_irq_seq uut (
        .clk(clk), .rst_n(rst_n), .octet_vld(octet_vld), .octet_data(octet_data),
        .sfd_det(sfd_det), .addr_match(addr_match), .hdr_len(hdr_len),
        .abort(abort), .tx_done(tx_done), .stat_rd(stat_rd),
        .irq_mask(irq_mask), .irq_stat(irq_stat), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic bit want_match(int len, int m, bit mt);
        return mt && (m >= 1) && (m + 2 < len);
    endfunction

    task automatic chk_stat(string tag);
        checks++;
        if (irq_stat !== exp_stat) begin
            errors++;
            $display("FAIL %s irq_stat act=%0b exp=%0b", tag, irq_stat, exp_stat);
        end
        checks++;
        if (irq !== |(exp_stat & irq_mask)) begin
            errors++;
            $display("FAIL R10 irq act=%0b exp=%0b", irq, |(exp_stat & irq_mask));
        end
    endtask

    task automatic read_clear();
        stat_rd = 1'b1;
        tick();
        stat_rd = 1'b0;
        exp_stat = '0;
        chk_stat("R11");
    endtask

    task automatic stray_octets(string tag);
        for (int k = 0; k < 3; k++) begin
            octet_vld = 1'b1;
            octet_data = 8'($urandom_range(1, 255));
            addr_match = 1'b1;
            tick();
        end
        octet_vld = 1'b0;
        addr_match = 1'b0;
        chk_stat(tag);
    endtask

    task automatic rx_frame(int len, int m, bit mt, int abort_at, bit rd_last);
        hdr_len = 7'(m);
        sfd_det = 1'b1;
        tick();
        sfd_det = 1'b0;
        octet_vld = 1'b1;
        octet_data = 8'(len);
        tick();
        octet_vld = 1'b0;
        if (len != 0) begin
            exp_stat[0] = 1'b1;
            chk_stat("R2");
        end else begin
            chk_stat("R3");
            stray_octets("R3");
            return;
        end
        hdr_len = 7'($urandom_range(0, 127));   // R12: late change
        for (int i = 1; i <= len; i++) begin
            if (i == abort_at) begin
                abort = 1'b1;
                octet_vld = 1'b1;
                tick();
                abort = 1'b0;
                octet_vld = 1'b0;
                chk_stat("R8");
                stray_octets("R8");
                return;
            end
            addr_match = (i == m) ? mt : 1'($urandom_range(0, 1));
            sfd_det = (i == 2);
            octet_vld = 1'b1;
            octet_data = 8'($urandom_range(0, 255));
            if (i == len && rd_last) begin
                stat_rd = 1'b1;
                exp_stat = '0;
            end
            tick();
            octet_vld = 1'b0;
            sfd_det = 1'b0;
            stat_rd = 1'b0;
            addr_match = 1'b0;
            if (i == m && want_match(len, m, mt)) exp_stat[1] = 1'b1;
            if (i == len) exp_stat[2] = 1'b1;
            if (i == len && rd_last)          chk_stat("R11");
            else if (i == len)                chk_stat("R6");
            else if (i == m && want_match(len, m, mt)) chk_stat("R4");
            else if (i == m)                  chk_stat("R5");
            else if (i == 2)                  chk_stat("R9");
            else                              chk_stat("R12");
        end
        stray_octets("R6");
    endtask

    initial begin
        void'($urandom(32'd20417));
        repeat (3) tick();
        exp_stat = '0;
        chk_stat("R1");
        rst_n = 1'b1;
        tick();
        stray_octets("R1");

        rx_frame(10, 4, 1'b1, 0, 1'b0);   read_clear();   // R4
        rx_frame(10, 4, 1'b0, 0, 1'b0);   read_clear();   // R5 no match
        rx_frame(6, 4, 1'b1, 0, 1'b0);    read_clear();   // R5 m+2 == L
        rx_frame(7, 4, 1'b1, 0, 1'b0);    read_clear();   // R4 boundary
        rx_frame(5, 0, 1'b1, 0, 1'b0);    read_clear();   // R5 m = 0
        rx_frame(0, 3, 1'b1, 0, 1'b0);    read_clear();   // R3
        rx_frame(1, 0, 1'b0, 0, 1'b0);    read_clear();   // R6 shortest
        rx_frame(127, 20, 1'b1, 0, 1'b0); read_clear();   // R6 longest
        rx_frame(12, 5, 1'b1, 3, 1'b0);   read_clear();   // R8
        rx_frame(12, 5, 1'b1, 12, 1'b0);  read_clear();   // R8 on last octet
        rx_frame(9, 3, 1'b1, 0, 1'b1);                    // R11 read with end

        // R7: transmit done, then transmit done together with a read
        tx_done = 1'b1;
        tick();
        tx_done = 1'b0;
        exp_stat[2] = 1'b1;
        chk_stat("R7");
        tx_done = 1'b1;
        stat_rd = 1'b1;
        tick();
        tx_done = 1'b0;
        stat_rd = 1'b0;
        exp_stat = 3'b100;
        chk_stat("R11");
        read_clear();

        // R10: masks with a pending bit
        rx_frame(8, 2, 1'b1, 0, 1'b0);
        for (int k = 0; k < 8; k++) begin
            irq_mask = 3'(k);
            #1;
            chk_stat("R10");
        end
        read_clear();

        for (int n = 0; n < 60; n++) begin
            int len = $urandom_range(0, 24);
            int m   = $urandom_range(0, len + 1);
            bit mt  = 1'($urandom_range(0, 1));
            int ab  = ($urandom_range(0, 5) == 0) ? $urandom_range(1, len + 1) : 0;
            bit rl  = ($urandom_range(0, 4) == 0);
            irq_mask = 3'($urandom_range(0, 7));
            rx_frame(len, m, mt, ab, rl);
            if ($urandom_range(0, 1) == 1) read_clear();
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule